// File: doc/BRIEF.md
# Landing-Pad Control-Flow Checker

This block guards forward control-flow edges. When an indirect jump retires with checking enabled, it moves an internal "pad expected" flag into the expected state. While that flag is expected, the next fetched instruction must be a 4-byte-aligned, uncompressed landing-pad instruction. When that landing pad executes, the label in its upper immediate is compared with the label the caller placed in bits 31:12 of register x7. A violation produces a one-cycle software-check fault carrying a cause and a trap value, which the surrounding trap logic consumes.

The landing pad is an add-upper-immediate-to-PC instruction (opcode 0010111) whose destination field is zero. It writes no register, so outside an expected window it is an ordinary no-op. Jumps through x1 or x5, which are returns, and jumps through x7, which are guarded by software, do not arm the check. Trap delivery, the register file and the pipeline stay outside this block. The block sees only strobes from the retire, fetch and execute stages and drives the flag and the fault.

Top module: `lp_cfi_checker`

## Requirements
- R1: A jump-retire strobe with `lp_en`=1 and an rs1 index other than 1, 5 or 7 sets `elp` to 1 on the next clock edge, unless a fault is raised in the same cycle.
- R2: A jump retiring through rs1 index 1, 5 or 7 never sets `elp`.
- R3: While `elp`=1 and `lp_en`=1, a fetch whose PC bits 1:0 are not 00 raises a fault.
- R4: While `elp`=1 and `lp_en`=1, a fetch flagged as compressed raises a fault.
- R5: While `elp`=1 and `lp_en`=1, a fetched word whose bits 6:0 are not 0010111, or whose bits 11:7 are not zero, raises a fault.
- R6: An executed landing pad with `elp`=1 and `lp_en`=1 faults when its label (bits 31:12) is nonzero and differs from `x7_label`. Otherwise it clears `elp`. With `elp`=0 it has no effect.
- R7: A fault appears one cycle after its cause as a single-cycle `fault_pulse` with `fault_cause`=18 and `fault_tval`=2. Both values read 0 when no fault is pulsed.
- R8: With `lp_en`=0, no fetch or execute check is made, no jump arms the flag, and `elp` holds its value.
- R9: A fetch that already carries `fetch_err` is not checked.
- R10: `elp` is left unchanged in a cycle that raises a fault, so trap logic can save it.
- R11: If an arming jump retires in the same cycle as a passing landing pad, `elp` ends at 1.
- R12: After synchronous reset, `elp`=0 and no fault is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_en | input | 1 | Landing-pad checking enable for the current privilege |
| jmp_retire | input | 1 | An indirect jump retired this cycle |
| jmp_rs1 | input | 5 | Source register index of that jump |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_insn | input | 32 | Fetched instruction word |
| fetch_rvc | input | 1 | Fetched instruction is 16-bit |
| fetch_pc | input | XLEN | PC of the fetched instruction |
| fetch_err | input | 1 | Fetch already carries an error |
| exec_valid | input | 1 | Execute strobe |
| exec_insn | input | 32 | Instruction being executed |
| x7_label | input | 20 | Bits 31:12 of register x7 |
| fault_pulse | output | 1 | Software-check fault, one cycle |
| fault_cause | output | CAUSE_W | Exception cause (18 on fault) |
| fault_tval | output | XLEN | Trap value (2 on fault) |
| elp | output | 1 | Landing pad expected |

## Verification
The main function is driven with arming jumps through ordinary, return and software-guarded registers. This separates a correct exemption list from one that is too wide or too narrow. Fetches after arming cover a correct pad and each way a fetch can be wrong: misaligned, compressed, wrong opcode and nonzero destination. Each one is checked to fault on its own. Executed pads are tried with a zero label, a matching label and a mismatching label, which separates the wildcard rule from plain equality. Disabled, error-tagged and same-cycle arm-and-clear patterns show the paths where no check is made and the order in which the flag is updated.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int SWCHK_CAUSE   = 18;  // software-check exception cause
  localparam int LP_FAULT_CODE = 2;   // trap value for a landing-pad fault
  localparam int SS_FAULT_CODE = 3;   // reserved for shadow-stack faults
  localparam logic [6:0] PAD_OPCODE = 7'b0010111;
  localparam int N_EXEMPT = 3;

  function automatic logic [4:0] exempt_reg(input int idx);
    case (idx)
      0:       exempt_reg = 5'd1;  // return link
      1:       exempt_reg = 5'd5;  // alternate return link
      default: exempt_reg = 5'd7;  // software-guarded jump
    endcase
  endfunction

  function automatic logic is_pad(input logic [31:0] w);
    is_pad = (w[6:0] == PAD_OPCODE) && (w[11:7] == 5'd0);
  endfunction
endpackage

// File: rtl/lpc_jump_arm.sv
module lpc_jump_arm
  import lpc_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              en,
  input  logic              retire,
  input  logic [RIDX_W-1:0] rs1,
  output logic              arm
);
  logic [N_EXEMPT-1:0] hit;

  for (genvar g = 0; g < N_EXEMPT; g++) begin : g_exempt
    assign hit[g] = (rs1 == RIDX_W'(exempt_reg(g)));
  end

  assign arm = en && retire && (hit == '0);
endmodule

// File: rtl/lpc_fetch_screen.sv
module lpc_fetch_screen
  import lpc_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic            en,
  input  logic            expect_pad,
  input  logic            valid,
  input  logic            err,
  input  logic            rvc,
  input  logic [1:0]      pc_lo,
  input  logic [ILEN-1:0] insn,
  output logic            fault
);
  logic bad_shape;

  always_comb begin
    bad_shape = (pc_lo != 2'b00) || rvc || !is_pad(insn[31:0]);
    fault     = en && expect_pad && valid && !err && bad_shape;
  end
endmodule

// File: rtl/lpc_label_cmp.sv
module lpc_label_cmp
  import lpc_pkg::*;
#(
  parameter int ILEN  = 32,
  parameter int LBL_W = 20
) (
  input  logic             en,
  input  logic             expect_pad,
  input  logic             valid,
  input  logic [ILEN-1:0]  insn,
  input  logic [LBL_W-1:0] want,
  output logic             pass,
  output logic             fault
);
  localparam int LBL_LO = ILEN - LBL_W;

  logic             live;
  logic [LBL_W-1:0] got;

  always_comb begin
    got   = insn[ILEN-1:LBL_LO];
    live  = en && expect_pad && valid && is_pad(insn[31:0]);
    fault = live && (got != '0) && (got != want);
    pass  = live && !fault;
  end
endmodule

// File: rtl/lp_cfi_checker.sv
module lp_cfi_checker
  import lpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lp_en,
  input  logic               jmp_retire,
  input  logic [4:0]         jmp_rs1,
  input  logic               fetch_valid,
  input  logic [31:0]        fetch_insn,
  input  logic               fetch_rvc,
  input  logic [XLEN-1:0]    fetch_pc,
  input  logic               fetch_err,
  input  logic               exec_valid,
  input  logic [31:0]        exec_insn,
  input  logic [19:0]        x7_label,
  output logic               fault_pulse,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic [XLEN-1:0]    fault_tval,
  output logic               elp
);
  localparam int ILEN  = 32;
  localparam int LBL_W = 20;

  logic arm, f_fault, x_fault, x_pass, any_fault;

  lpc_jump_arm #(.RIDX_W(5)) u_arm (
    .en(lp_en), .retire(jmp_retire), .rs1(jmp_rs1), .arm(arm)
  );

  lpc_fetch_screen #(.ILEN(ILEN)) u_fetch (
    .en(lp_en), .expect_pad(elp), .valid(fetch_valid), .err(fetch_err),
    .rvc(fetch_rvc), .pc_lo(fetch_pc[1:0]), .insn(fetch_insn), .fault(f_fault)
  );

  lpc_label_cmp #(.ILEN(ILEN), .LBL_W(LBL_W)) u_label (
    .en(lp_en), .expect_pad(elp), .valid(exec_valid), .insn(exec_insn),
    .want(x7_label), .pass(x_pass), .fault(x_fault)
  );

  assign any_fault = f_fault || x_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      elp         <= 1'b0;
      fault_pulse <= 1'b0;
      fault_cause <= '0;
      fault_tval  <= '0;
    end else begin
      fault_pulse <= any_fault;
      fault_cause <= any_fault ? CAUSE_W'(SWCHK_CAUSE) : '0;
      fault_tval  <= any_fault ? XLEN'(LP_FAULT_CODE) : '0;
      if (any_fault)   elp <= elp;    // held for the trap to save
      else if (arm)    elp <= 1'b1;   // arming wins over a same-cycle clear
      else if (x_pass) elp <= 1'b0;
    end
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
    (jmp_retire && lp_en && jmp_rs1 != 5'd1 && jmp_rs1 != 5'd5 && jmp_rs1 != 5'd7 && !any_fault) |=> elp); // R1
  AST_EXEMPT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!elp && !(jmp_retire && lp_en && jmp_rs1 != 5'd1 && jmp_rs1 != 5'd5 && jmp_rs1 != 5'd7)) |=> !elp); // R2
  AST_FAULT_CODES: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |-> (fault_cause == CAUSE_W'(18) && fault_tval == XLEN'(2))); // R7
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !lp_en |=> (!fault_pulse && elp == $past(elp))); // R8
  AST_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    any_fault |=> (fault_pulse && elp == $past(elp))); // R10
  AST_FAULT_NEEDS_ELP: assert property (@(posedge clk) disable iff (rst)
    !elp |=> !fault_pulse); // R6
endmodule

// File: tb/lp_cfi_checker_tb.sv
module lp_cfi_checker_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        lp_en, jmp_retire, fetch_valid, fetch_rvc, fetch_err, exec_valid;
  logic [4:0]  jmp_rs1;
  logic [31:0] fetch_insn, fetch_pc, exec_insn, fault_tval;
  logic [19:0] x7_label;
  logic        fault_pulse, elp;
  logic [4:0]  fault_cause;

  int n_cmp = 0, n_bad = 0;
  bit m_elp = 0, m_fault = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  lp_cfi_checker u_dut (
    .clk(clk), .rst(rst), .lp_en(lp_en), .jmp_retire(jmp_retire), .jmp_rs1(jmp_rs1),
    .fetch_valid(fetch_valid), .fetch_insn(fetch_insn), .fetch_rvc(fetch_rvc),
    .fetch_pc(fetch_pc), .fetch_err(fetch_err), .exec_valid(exec_valid),
    .exec_insn(exec_insn), .x7_label(x7_label), .fault_pulse(fault_pulse),
    .fault_cause(fault_cause), .fault_tval(fault_tval), .elp(elp)
  );

  localparam logic [31:0] PAD0 = 32'h0000_0017;  // landing pad, label 0

  function automatic logic [31:0] pad(input logic [19:0] l);
    return {l, 5'd0, 7'b0010111};
  endfunction

  task automatic idle();
    jmp_retire = 0; jmp_rs1 = 0; fetch_valid = 0; fetch_insn = 0; fetch_rvc = 0;
    fetch_pc = 0; fetch_err = 0; exec_valid = 0; exec_insn = 0;
  endtask

  // Reference: apply this cycle's inputs to the model, clock, then compare.
  task automatic step(input string tag);
    bit pad_f, pad_x, ff, xf, xp, armj;
    pad_f = fetch_insn[6:0] == 7'h17 && fetch_insn[11:7] == 0;
    pad_x = exec_insn[6:0] == 7'h17 && exec_insn[11:7] == 0;
    ff = lp_en && m_elp && fetch_valid && !fetch_err &&
         (fetch_pc[1:0] != 0 || fetch_rvc || !pad_f);
    xf = lp_en && m_elp && exec_valid && pad_x && exec_insn[31:12] != 0 &&
         exec_insn[31:12] != x7_label;
    xp = lp_en && m_elp && exec_valid && pad_x && !xf;
    armj = lp_en && jmp_retire && !(jmp_rs1 inside {5'd1, 5'd5, 5'd7});
    m_fault = ff || xf;
    if (!m_fault) begin
      if (armj) m_elp = 1;
      else if (xp) m_elp = 0;
    end
    @(posedge clk); #1;
    compare(tag);
    idle();
  endtask

  task automatic compare(input string tag);
    logic [4:0]  ec = m_fault ? 5'd18 : 5'd0;
    logic [31:0] et = m_fault ? 32'd2 : 32'd0;
    n_cmp++;
    if (elp !== m_elp || fault_pulse !== m_fault || fault_cause !== ec || fault_tval !== et) begin
      n_bad++;
      $display("FAIL %s: elp=%0d fault=%0d cause=%0d tval=%0d expected elp=%0d fault=%0d cause=%0d tval=%0d",
               tag, elp, fault_pulse, fault_cause, fault_tval, m_elp, m_fault, ec, et);
    end
  endtask

  task automatic arm_jump(input string tag);
    jmp_retire = 1; jmp_rs1 = 5'd6; step(tag);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(); lp_en = 1; x7_label = 20'h00abc; rst = 1;
    @(posedge clk); @(posedge clk); #1;
    rst = 0; m_elp = 0; m_fault = 0;
    compare("R12 reset");

    // R1 arm, then a good pad fetch and a zero-label execute (R6 wildcard)
    arm_jump("R1 arm via x6");
    fetch_valid = 1; fetch_insn = PAD0; fetch_pc = 32'h100; step("R5 good pad fetch");
    exec_valid = 1; exec_insn = PAD0; step("R6 zero label clears");
    jmp_retire = 1; jmp_rs1 = 5'd0; step("R1 arm via x0");
    exec_valid = 1; exec_insn = pad(20'h00abc); step("R6 matching label clears");

    // R3 misaligned, R10 held, R7 pulse drops
    arm_jump("R1 arm");
    fetch_valid = 1; fetch_insn = PAD0; fetch_pc = 32'h102; step("R3 misaligned fetch");
    step("R7 pulse lasts one cycle");
    fetch_valid = 1; fetch_insn = PAD0; fetch_pc = 32'h101; step("R3 odd PC");
    fetch_valid = 1; fetch_insn = PAD0; fetch_rvc = 1; step("R4 compressed fetch");
    fetch_valid = 1; fetch_insn = 32'h0000_0013; step("R5 wrong opcode");
    fetch_valid = 1; fetch_insn = 32'h0000_0197; step("R5 nonzero rd");
    fetch_valid = 1; fetch_insn = PAD0; fetch_pc = 32'h104; exec_valid = 1;
    exec_insn = pad(20'h12345); step("R6 label mismatch faults, R10 hold");
    exec_valid = 1; exec_insn = pad(20'h00abc); step("R6 clear after retry");

    // R2 exemptions
    jmp_retire = 1; jmp_rs1 = 5'd1; step("R2 x1 exempt");
    jmp_retire = 1; jmp_rs1 = 5'd5; step("R2 x5 exempt");
    jmp_retire = 1; jmp_rs1 = 5'd7; step("R2 x7 exempt");
    exec_valid = 1; exec_insn = pad(20'h55555); step("R6 pad no-op when idle");

    // R8 disabled
    lp_en = 0; jmp_retire = 1; jmp_rs1 = 5'd9; step("R8 disabled jump no arm");
    lp_en = 1; arm_jump("R1 arm before disable");
    lp_en = 0; fetch_valid = 1; fetch_insn = 32'h0000_0013; fetch_pc = 32'h3;
    step("R8 disabled fetch unchecked");
    lp_en = 0; exec_valid = 1; exec_insn = pad(20'h77777); step("R8 disabled pad keeps elp");
    lp_en = 0; exec_valid = 1; exec_insn = PAD0; step("R8 disabled pad no clear");
    lp_en = 1;

    // R9 error-tagged fetch
    fetch_valid = 1; fetch_err = 1; fetch_insn = 32'h0000_0013; fetch_rvc = 1;
    step("R9 errored fetch unchecked");

    // R11 arm and clear in the same cycle
    exec_valid = 1; exec_insn = PAD0; jmp_retire = 1; jmp_rs1 = 5'd12;
    step("R11 arm beats clear");
    exec_valid = 1; exec_insn = PAD0; step("R6 clear");

    // R12 reset while expected
    arm_jump("R1 arm before reset");
    rst = 1; @(posedge clk); #1; rst = 0; m_elp = 0; m_fault = 0;
    compare("R12 reset clears elp");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule